// File: doc/BRIEF.md
# Bus-Slave Pulse-Width Modulator

This block is a slave on a synchronous, OR-combined on-chip peripheral bus. A master selects it and places an address in its window. The block answers with a registered one-cycle acknowledge, or with an error acknowledge when the offset maps to no register. It holds a period value and a duty value for each PWM channel, and it drives one PWM output bit per channel.

Every bus-facing output is forced to zero whenever the block is not the addressed slave, because the bus merges slaves with OR gates and has no tristate drivers. Each channel runs a free counter from zero up to its period value and then wraps. The channel output is high while the counter is below the duty value.

Top module: `pwm_slave_top`

## Requirements
- R1: The block responds only when `sel_i` is high and `addr_i` lies between `BASE_ADDR` and `HIGH_ADDR` inclusive. The defaults are 0xFFFF8000 and 0xFFFF80FF. A selected access outside that window gets no response and changes no register.
- R2: When the block is not both selected and addressed, `rdata_o`, `xfer_ack_o`, `err_ack_o`, `retry_o` and `tout_sup_o` are all zero.
- R3: Suppose an accepted access is presented in cycle t. `xfer_ack_o` is then high for exactly one cycle, in cycle t+1, and read data is valid on `rdata_o` in that same cycle. If the select is held high, the block accepts the access again only after a one-cycle gap, so the acknowledge recurs every second cycle.
- R4: Channel n has its period register at byte offset 8*n and its duty register at offset 8*n+4, counted from `BASE_ADDR`. An access to any other offset in the window, including an unaligned one or one at or beyond channel `NUM_CH`, gives `err_ack_o` instead of `xfer_ack_o` and changes no register.
- R5: On a write, `be_i[0]` enables `wdata_i[31:24]` (bits 0 to 7 in big-endian numbering), `be_i[1]` enables `[23:16]`, `be_i[2]` enables `[15:8]` and `be_i[3]` enables `[7:0]`. Lanes that are not enabled keep their old contents.
- R6: Each register is `RES` bits wide and sits in the low bits of the data word. Bits above `RES` are dropped on a write and read back as zero.
- R7: On each clock, a channel counter that is at or above its period value returns to 0; otherwise it increments. `pwm_o[n]` is high exactly while the counter of channel n is below its duty value, so a duty of 0 holds the output low.
- R8: `retry_o` and `tout_sup_o` stay zero. Every accepted access is answered in the next cycle, well inside the 16-cycle bus timeout.
- R9: After reset, all period and duty registers read zero and all PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 32 | Byte address |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not responding |
| xfer_ack_o | output | 1 | Transfer acknowledge |
| err_ack_o | output | 1 | Error acknowledge |
| retry_o | output | 1 | Retry, always zero |
| tout_sup_o | output | 1 | Timeout suppress, always zero |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Random accesses mix reads and writes to valid registers with offsets past the last channel and unaligned offsets. These tell a correct offset decode apart from one that wraps the channel index or ignores the low address bits. Random byte-enable patterns separate correct lane steering from a reversed lane order. Random period and duty values show the wrap rule and the compare rule separately. Directed cases cover an address one word below and one byte above the window, a select held across several cycles, an all-ones write, and duty values of zero and of more than the period.

// File: rtl/pwm_slave_pkg.sv
package pwm_slave_pkg;
  localparam int unsigned BUS_AW = 32;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_BE = BUS_DW / 8;

  typedef enum logic {
    KIND_PERIOD = 1'b0,
    KIND_DUTY   = 1'b1
  } reg_kind_e;

  typedef struct packed {
    logic      valid;
    reg_kind_e kind;
    logic [7:0] ch;
  } reg_sel_t;

  // big-endian lanes: be[0] steers the most significant byte
  function automatic logic [BUS_DW-1:0] lane_merge(input logic [BUS_DW-1:0] old_v,
                                                   input logic [BUS_DW-1:0] new_v,
                                                   input logic [BUS_BE-1:0] be);
    logic [BUS_DW-1:0] res;
    res = old_v;
    for (int l = 0; l < BUS_BE; l++) begin
      if (be[l]) res[BUS_DW-1-8*l -: 8] = new_v[BUS_DW-1-8*l -: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_slave_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_8000,
  parameter logic [31:0] HIGH_ADDR = 32'hFFFF_80FF,
  parameter int unsigned NUM_CH    = 4
) (
  input  logic              sel_i,
  input  logic [BUS_AW-1:0] addr_i,
  output logic              hit_o,
  output reg_sel_t          rsel_o
);
  localparam int unsigned SLOT_W = BUS_AW - 3;
  localparam logic [SLOT_W-1:0] NUM_SLOTS = SLOT_W'(NUM_CH);

  logic [BUS_AW-1:0] off;
  logic [SLOT_W-1:0] slot;

  assign off   = addr_i - BASE_ADDR;
  assign slot  = off[BUS_AW-1:3];
  assign hit_o = sel_i && (addr_i >= BASE_ADDR) && (addr_i <= HIGH_ADDR);

  always_comb begin
    rsel_o.valid = (off[1:0] == 2'b00) && (slot < NUM_SLOTS);
    rsel_o.kind  = off[2] ? KIND_DUTY : KIND_PERIOD;
    rsel_o.ch    = slot[7:0];
  end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_slave_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  reg_sel_t                     rsel_i,
  input  logic [BUS_BE-1:0]            be_i,
  input  logic [BUS_DW-1:0]            wdata_i,
  output logic [BUS_DW-1:0]            rdata_o,
  output logic [NUM_CH-1:0][RES-1:0]   per_o,
  output logic [NUM_CH-1:0][RES-1:0]   duty_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [BUS_DW-1:0] per_w, duty_w, per_m, duty_m;
    logic              here;

    always_comb begin
      per_w  = '0;
      duty_w = '0;
      per_w[RES-1:0]  = per_o[i];
      duty_w[RES-1:0] = duty_o[i];
    end

    assign per_m  = lane_merge(per_w, wdata_i, be_i);
    assign duty_m = lane_merge(duty_w, wdata_i, be_i);
    assign here   = wr_en_i && rsel_i.valid && (rsel_i.ch == 8'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_o[i]  <= '0;
        duty_o[i] <= '0;
      end else if (here) begin
        if (rsel_i.kind == KIND_PERIOD) per_o[i] <= per_m[RES-1:0];
        else                            duty_o[i] <= duty_m[RES-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rsel_i.valid && rsel_i.ch == 8'(i)) begin
        if (rsel_i.kind == KIND_PERIOD) rdata_o[RES-1:0] = per_o[i];
        else                            rdata_o[RES-1:0] = duty_o[i];
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned RES = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RES-1:0] period_i,
  input  logic [RES-1:0] duty_i,
  output logic           pwm_o
);
  logic [RES-1:0] cnt_q;

  // >= so a period lowered below the count still wraps at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q >= period_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = cnt_q < duty_i;

  assert_duty_zero_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> !pwm_o);
endmodule

// File: rtl/pwm_slave_top.sv
module pwm_slave_top
  import pwm_slave_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_8000,
  parameter logic [31:0] HIGH_ADDR = 32'hFFFF_80FF,
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned RES       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rnw_i,
  input  logic [31:0]       addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              xfer_ack_o,
  output logic              err_ack_o,
  output logic              retry_o,
  output logic              tout_sup_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic                       hit, start, wr_en;
  reg_sel_t                   rsel;
  logic [BUS_DW-1:0]          rd_val, rdata_q;
  logic                       ack_q, err_q;
  logic [NUM_CH-1:0][RES-1:0] per, duty;

  pwm_bus_decode #(
    .BASE_ADDR(BASE_ADDR), .HIGH_ADDR(HIGH_ADDR), .NUM_CH(NUM_CH)
  ) u_dec (
    .sel_i (sel_i),
    .addr_i(addr_i),
    .hit_o (hit),
    .rsel_o(rsel)
  );

  // one idle cycle after each response so a held select is not double-counted
  assign start = hit && !(ack_q || err_q);
  assign wr_en = start && !rnw_i;

  pwm_regfile #(.NUM_CH(NUM_CH), .RES(RES)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .rsel_i (rsel),
    .be_i   (be_i),
    .wdata_i(wdata_i),
    .rdata_o(rd_val),
    .per_o  (per),
    .duty_o (duty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= start && rsel.valid;
      err_q   <= start && !rsel.valid;
      rdata_q <= (start && rnw_i && rsel.valid) ? rd_val : '0;
    end
  end

  // OR-combined bus: everything zero unless addressed
  assign xfer_ack_o = ack_q && hit;
  assign err_ack_o  = err_q && hit;
  assign rdata_o    = (ack_q && hit) ? rdata_q : '0;
  assign retry_o    = 1'b0;
  assign tout_sup_o = 1'b0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pwm
    pwm_channel #(.RES(RES)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .period_i(per[c]),
      .duty_i  (duty[c]),
      .pwm_o   (pwm_o[c])
    );
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (rdata_o == '0 && !xfer_ack_o && !err_ack_o && !retry_o && !tout_sup_o));

  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |=> !xfer_ack_o);

  assert_ack_err_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_ack_o && err_ack_o));

  assert_resp_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !xfer_ack_o && !err_ack_o && !$past(xfer_ack_o || err_ack_o))
      |=> (!hit || xfer_ack_o || err_ack_o));
endmodule

// File: tb/pwm_slave_top_tb_top.sv
module pwm_slave_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [31:0] BASE = 32'hFFFF_8000;
  localparam logic [31:0] HIGH = 32'hFFFF_80FF;
  localparam logic [31:0] RMASK = 32'h0000_FFFF;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_i = 1'b0, rnw_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [3:0] be_i = '0;
  logic [31:0] rdata_o;
  logic xfer_ack_o, err_ack_o, retry_o, tout_sup_o;
  logic [NCH-1:0] pwm_o;

  pwm_slave_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .rnw_i(rnw_i),
    .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .xfer_ack_o(xfer_ack_o), .err_ack_o(err_ack_o), .retry_o(retry_o),
    .tout_sup_o(tout_sup_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_per[NCH], m_duty[NCH], m_cnt[NCH];
  bit pend = 0;
  int pend_ch; bit pend_duty; logic [3:0] pend_be; logic [31:0] pend_d;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int l = 0; l < 4; l++) if (be[l]) r[31-8*l -: 8] = n[31-8*l -: 8];
    return r & RMASK;
  endfunction

  function automatic bit valid_off(logic [31:0] a);
    logic [31:0] off = a - BASE;
    return (off[1:0] == 0) && ((off >> 3) < NCH);
  endfunction

  // one clock: model steps with pre-edge registers, then pending write lands
  task automatic cycle();
    @(posedge clk_i);
    for (int c = 0; c < NCH; c++)
      m_cnt[c] = (m_cnt[c] >= m_per[c]) ? 32'd0 : m_cnt[c] + 1;
    if (pend) begin
      if (pend_duty) m_duty[pend_ch] = merge(m_duty[pend_ch], pend_d, pend_be);
      else           m_per[pend_ch]  = merge(m_per[pend_ch], pend_d, pend_be);
      pend = 0;
    end
    @(negedge clk_i);
    for (int c = 0; c < NCH; c++)
      chk("R7 pwm", 32'(pwm_o[c]), 32'(m_cnt[c] < m_duty[c]));
  endtask

  task automatic quiet_check(string req);
    #1;
    chk(req, rdata_o, 0);
    chk(req, {xfer_ack_o, err_ack_o, retry_o, tout_sup_o}, 0);
  endtask

  task automatic access(bit rnw, logic [31:0] a, logic [3:0] be, logic [31:0] d);
    bit in_win = (a >= BASE) && (a <= HIGH);
    bit ok = valid_off(a);
    logic [31:0] off = a - BASE;
    logic [31:0] exp_rd = 0;
    if (rnw && in_win && ok) exp_rd = off[2] ? m_duty[off>>3] : m_per[off>>3];
    sel_i = 1; rnw_i = rnw; addr_i = a; be_i = be; wdata_i = d;
    if (!rnw && in_win && ok) begin
      pend = 1; pend_ch = int'(off >> 3); pend_duty = off[2]; pend_be = be; pend_d = d;
    end
    cycle();
    chk("R3 ack", 32'(xfer_ack_o), 32'(in_win && ok));
    chk("R4 err", 32'(err_ack_o), 32'(in_win && !ok));
    chk("R3 rdata", rdata_o, exp_rd);
    chk("R8 retry/tsup", {retry_o, tout_sup_o}, 0);
    sel_i = 0;
    quiet_check("R2 after drop");
    cycle();
  endtask

  task automatic read_exp(string req, logic [31:0] a, logic [31:0] exp);
    sel_i = 1; rnw_i = 1; addr_i = a; be_i = 4'hF;
    cycle();
    chk(req, rdata_o, exp);
    sel_i = 0;
    cycle();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int c = 0; c < NCH; c++) begin m_per[c] = 0; m_duty[c] = 0; m_cnt[c] = 0; end
    repeat (3) @(negedge clk_i);
    chk("R9 pwm reset", 32'(pwm_o), 0);
    quiet_check("R2 reset");
    rst_ni = 1;
    cycle();
    for (int c = 0; c < NCH; c++) begin
      read_exp("R9 per reset", BASE + 8*c, 0);
      read_exp("R9 duty reset", BASE + 8*c + 4, 0);
    end
    // R7 directed: duty 3 of period 9, duty 0, duty above period
    access(0, BASE + 0, 4'hF, 32'd9);
    access(0, BASE + 4, 4'hF, 32'd3);
    access(0, BASE + 8, 4'hF, 32'd5);
    access(0, BASE + 12, 4'hF, 32'd0);
    access(0, BASE + 16, 4'hF, 32'd2);
    access(0, BASE + 20, 4'hF, 32'd7);
    repeat (25) cycle();
    // R6 upper bits dropped
    access(0, BASE + 24, 4'hF, 32'hFFFF_FFFF);
    read_exp("R6 width", BASE + 24, 32'h0000_FFFF);
    // R5 single lanes
    access(0, BASE + 24, 4'b1000, 32'h1122_3344);
    read_exp("R5 lane3", BASE + 24, 32'h0000_FF44);
    access(0, BASE + 24, 4'b0100, 32'h1122_3344);
    read_exp("R5 lane2", BASE + 24, 32'h0000_3344);
    access(0, BASE + 24, 4'b0011, 32'hAABB_0000);
    read_exp("R5 lanes01", BASE + 24, 32'h0000_3344);
    access(0, BASE + 24, 4'hF, 32'd4);
    // R4 error offsets leave registers intact
    access(0, BASE + 32, 4'hF, 32'd77);
    access(0, BASE + 2, 4'hF, 32'd77);
    access(1, BASE + 8*NCH + 4, 4'hF, 0);
    read_exp("R4 untouched", BASE + 0, 32'd9);
    // R1 just outside the window: no response, no write
    sel_i = 1; rnw_i = 0; addr_i = BASE - 4; be_i = 4'hF; wdata_i = 32'd55;
    cycle(); quiet_check("R1 below window");
    addr_i = HIGH + 1;
    cycle(); quiet_check("R1 above window");
    sel_i = 0; cycle();
    // R2 in-window address without select
    addr_i = BASE; rnw_i = 1;
    cycle(); quiet_check("R2 unselected");
    read_exp("R1 no write", BASE + 0, 32'd9);
    // R3 held select: ack, gap, ack
    sel_i = 1; rnw_i = 1; addr_i = BASE + 4; be_i = 4'hF;
    cycle(); chk("R3 held 1", {xfer_ack_o, rdata_o}, {1'b1, 32'd3});
    cycle(); chk("R3 held gap", 32'(xfer_ack_o), 0);
    cycle(); chk("R3 held 2", {xfer_ack_o, rdata_o}, {1'b1, 32'd3});
    sel_i = 0; cycle();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int ch = $urandom_range(0, NCH + 1);
      logic [31:0] a = BASE + 8*ch + 4*$urandom_range(0, 1);
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? $urandom : $urandom_range(0, 24);
      if ($urandom_range(0, 7) == 0) a = a + $urandom_range(1, 3);
      access($urandom_range(0, 1), a, 4'($urandom), d);
      repeat ($urandom_range(0, 3)) cycle();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule